// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block gathers a set of interrupt inputs, ranks them by a programmable priority, and tells a processor through one active-low request line that an interrupt is waiting. Every source has its own configuration word (priority, trigger mode, enable) and its own stored handler vector. Software answers the request by reading a vector register. That read returns the handler vector of the winning source and makes that source the one in service. The read also clears the source's latched edge if it is edge-triggered and pushes its priority onto a small hardware stack of levels.

Nesting comes from that stack. While an interrupt is in service, the request line rises again only for an enabled pending source whose priority is strictly above the level on top of the stack. Writing the end-of-interrupt register pops one level. The request line then answers to the level below it, so a source that was held off can now be requested even though its priority is at or below the level that just ended. A read when nothing beats the current level returns a programmable default vector and changes nothing.

Top module: `pvic_top`

## Requirements
- R1: After reset the request line `irq_n` is high, every configuration word and every vector register reads 0, the default vector is 0, and the level stack is empty.
- R2: Address layout: configuration word of source i at address i (0..7), with bits [2:0] the priority (0 lowest, 7 highest), bit 3 the trigger mode (1 edge, 0 level) and bit 4 the enable; all other bits read 0. The vector of source i is at address 8+i, the vector read at 16, end-of-interrupt at 17 (write only) and the default vector at 18. Configuration, vector and default registers read back what was written.
- R3: `irq_n` is low exactly when an enabled pending source exists and either the stack is empty or that source's priority is strictly greater than the level on top of the stack; disabled sources never pull it low.
- R4: The candidate is the enabled pending source with the highest priority; among equal priorities the lowest source index wins. A read of address 16 returns the candidate's vector.
- R5: A vector read that finds a candidate beating the current level commits it: its priority is pushed and becomes the current level from the next cycle, so `irq_n` returns high unless a strictly higher source is pending.
- R6: A committed edge-triggered source loses its pending state; a level-triggered source is never cleared by the block and stays pending while its input is high.
- R7: A vector read with no candidate beating the current level returns the default vector, pushes nothing and clears nothing.
- R8: A write to address 17 with a non-empty stack pops one level; `irq_n` then follows R3 against the restored level (or the empty stack), even for a source whose priority is at or below the level just ended.
- R9: A write to address 17 with an empty stack has no effect.
- R10: In edge mode a source becomes pending only on a rising edge of its synchronised input; an input held high after its commit does not make it pending again. In level mode nothing is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 8 | Interrupt source inputs, asynchronous to the clock |
| bus_rd | input | 1 | Read strobe for one cycle; read data is valid in that cycle |
| bus_wr | input | 1 | Write strobe for one cycle; a write wins over a read |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The arbitration is tried with sources that share a priority, so that the tie rule shows, and with sources of different priorities raised in various orders. Nested sequences raise a source of equal priority, then a strictly higher one, during service, and then pop the level. This separates a strict comparison against the current level from a non-strict one and from a comparison against the ended level. Edge and level sources are each committed while their inputs stay high, which shows whether the clear acts only on edge sources and whether a held edge input can re-arm itself. A long stretch of seeded random toggles, reconfigurations, vector reads and end-of-interrupt writes is compared with a bench model of pending state and the level stack, including redundant pops and default-vector reads.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    // Offsets inside one source configuration word (priority occupies the low bits)
    localparam int CFG_EDGE_OFS = 0;   // added to the priority width
    localparam int CFG_EN_OFS   = 1;   // added to the priority width

    // Region selector produced by the address decoder
    typedef enum logic [2:0] {
        REG_NONE,
        REG_CFG,
        REG_VEC,
        REG_IVR,
        REG_EOI,
        REG_DFLT
    } reg_kind_e;
endpackage

// File: rtl/pvic_src_cond.sv
module pvic_src_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic edge_md_i,
    input  logic clr_i,
    output logic pend_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
        logic epend;
    } cond_t;

    cond_t st_q, st_d;
    logic  rise;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = src_i;
        st_d.s2 = st_q.s1;
        st_d.prev = st_q.s2;
        rise    = st_q.s2 & ~st_q.prev;
        if (edge_md_i) begin
            st_d.epend = (st_q.epend & ~clr_i) | rise;
        end else begin
            st_d.epend = 1'b0;
        end
        pend_o = edge_md_i ? st_q.epend : st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A detected rising edge in edge mode must be held as pending
    assert_edge_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md_i && rise) |=> st_q.epend);

    // A commit without a simultaneous new edge must drop the latched edge
    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md_i && clr_i && !rise) |=> !st_q.epend);
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter #(
    parameter int NUM_SRC = 8,
    parameter int PRIO_W  = 3,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic [NUM_SRC-1:0]        elig_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    output logic                      valid_o,
    output logic [IDX_W-1:0]          idx_o,
    output logic [PRIO_W-1:0]         prio_o,
    output logic [NUM_SRC-1:0]        grant_o
);
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        grant_o = '0;
        // Walk from the top index down; ">=" lets a lower index take an equal priority
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (elig_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] >= prio_o))) begin
                valid_o = 1'b1;
                idx_o   = IDX_W'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
        if (valid_o) begin
            grant_o[idx_o] = 1'b1;
        end
    end
endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack #(
    parameter int DEPTH = 8,
    parameter int LVL_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [LVL_W-1:0] push_lvl_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] top_o,
    output logic             empty_o,
    output logic             full_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic [DEPTH-1:0][LVL_W-1:0] mem;
        logic [CNT_W-1:0]            cnt;
    } stk_t;

    stk_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        empty_o = (st_q.cnt == '0);
        full_o  = (st_q.cnt == CNT_W'(DEPTH));
        top_o   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (int'(st_q.cnt) == i + 1) begin
                top_o = st_q.mem[i];
            end
        end
        if (push_i && !full_o) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (int'(st_q.cnt) == i) begin
                    st_d.mem[i] = push_lvl_i;
                end
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (pop_i && !empty_o) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        cnt_o = st_q.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Strictly rising levels bound the nesting depth, so a push never meets a full stack
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o);

    assert_push_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> (top_o == $past(push_lvl_i)) && (cnt_o == $past(cnt_o) + 1'b1));

    assert_pop_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);

    assert_pop_cnt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i) |=> (cnt_o == $past(cnt_o) - 1'b1));
endmodule

// File: rtl/pvic_top.sv
module pvic_top #(
    parameter int NUM_SRC   = 8,
    parameter int PRIO_W    = 3,
    parameter int VEC_W     = 32,
    parameter int STK_DEPTH = 8,
    parameter int ADDR_W    = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [VEC_W-1:0]   bus_wdata,
    output logic [VEC_W-1:0]   bus_rdata,
    output logic               irq_n
);
    import pvic_pkg::*;

    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int CFG_W  = PRIO_W + 2;
    localparam int EDGE_B = PRIO_W + CFG_EDGE_OFS;
    localparam int EN_B   = PRIO_W + CFG_EN_OFS;
    localparam int A_IVR  = 2 * NUM_SRC;
    localparam int A_EOI  = 2 * NUM_SRC + 1;
    localparam int A_DFLT = 2 * NUM_SRC + 2;
    localparam int CNT_W  = $clog2(STK_DEPTH + 1);

    typedef struct packed {
        logic [NUM_SRC-1:0][CFG_W-1:0] cfg;
        logic [NUM_SRC-1:0][VEC_W-1:0] vec;
        logic [VEC_W-1:0]              dflt;
    } regs_t;

    regs_t regs_q, regs_d;

    reg_kind_e                 kind;
    logic [IDX_W-1:0]          sel_idx;
    logic [NUM_SRC-1:0]        pend;
    logic [NUM_SRC-1:0]        elig;
    logic [NUM_SRC-1:0]        edge_md;
    logic [NUM_SRC-1:0]        clr;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic                      cand_valid;
    logic [IDX_W-1:0]          cand_idx;
    logic [PRIO_W-1:0]         cand_prio;
    logic [NUM_SRC-1:0]        grant;
    logic                      beats;
    logic                      vec_rd;
    logic                      eoi_wr;
    logic                      commit;
    logic                      pop;
    logic [PRIO_W-1:0]         stk_top;
    logic                      stk_empty;
    logic                      stk_full;
    logic [CNT_W-1:0]          stk_cnt;

    // Address decoding into a region and an index inside it
    always_comb begin
        kind    = REG_NONE;
        sel_idx = '0;
        if (int'(bus_addr) < NUM_SRC) begin
            kind    = REG_CFG;
            sel_idx = IDX_W'(int'(bus_addr));
        end else if (int'(bus_addr) < 2 * NUM_SRC) begin
            kind    = REG_VEC;
            sel_idx = IDX_W'(int'(bus_addr) - NUM_SRC);
        end else if (int'(bus_addr) == A_IVR) begin
            kind = REG_IVR;
        end else if (int'(bus_addr) == A_EOI) begin
            kind = REG_EOI;
        end else if (int'(bus_addr) == A_DFLT) begin
            kind = REG_DFLT;
        end
    end

    // Per-source conditioning: synchroniser, edge latch, level pass-through
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign edge_md[g] = regs_q.cfg[g][EDGE_B];
        assign elig[g]    = pend[g] & regs_q.cfg[g][EN_B];
        assign prio_flat[g*PRIO_W +: PRIO_W] = regs_q.cfg[g][PRIO_W-1:0];
        assign clr[g]     = commit & grant[g];

        pvic_src_cond u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .src_i     (src_i[g]),
            .edge_md_i (edge_md[g]),
            .clr_i     (clr[g]),
            .pend_o    (pend[g])
        );
    end

    pvic_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W)
    ) u_arb (
        .elig_i  (elig),
        .prio_i  (prio_flat),
        .valid_o (cand_valid),
        .idx_o   (cand_idx),
        .prio_o  (cand_prio),
        .grant_o (grant)
    );

    pvic_lvl_stack #(
        .DEPTH (STK_DEPTH),
        .LVL_W (PRIO_W)
    ) u_stk (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (commit),
        .push_lvl_i (cand_prio),
        .pop_i      (pop),
        .top_o      (stk_top),
        .empty_o    (stk_empty),
        .full_o     (stk_full),
        .cnt_o      (stk_cnt)
    );

    // Control, register update and read mux
    always_comb begin
        regs_d = regs_q;
        beats  = cand_valid & (stk_empty | (cand_prio > stk_top));
        vec_rd = bus_rd & ~bus_wr & (kind == REG_IVR);
        eoi_wr = bus_wr & (kind == REG_EOI);
        commit = vec_rd & beats;
        pop    = eoi_wr & ~stk_empty;
        irq_n  = ~beats;

        if (bus_wr) begin
            unique case (kind)
                REG_CFG:  regs_d.cfg[sel_idx] = bus_wdata[CFG_W-1:0];
                REG_VEC:  regs_d.vec[sel_idx] = bus_wdata;
                REG_DFLT: regs_d.dflt         = bus_wdata;
                default:  ;
            endcase
        end

        bus_rdata = '0;
        unique case (kind)
            REG_CFG:  bus_rdata = VEC_W'(regs_q.cfg[sel_idx]);
            REG_VEC:  bus_rdata = regs_q.vec[sel_idx];
            REG_IVR:  bus_rdata = beats ? regs_q.vec[cand_idx] : regs_q.dflt;
            REG_DFLT: bus_rdata = regs_q.dflt;
            default:  bus_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // The arbiter never selects more than one source
    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (cand_valid == (elig != '0)));

    // A read that finds nothing above the current level leaves the stack alone
    assert_dflt_nopush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !beats && !bus_wr) |=> $stable(stk_cnt));

    // An end-of-interrupt with nothing in service leaves the stack alone
    assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_wr && stk_empty) |=> (stk_cnt == '0));

    // After a commit an interrupt is in service
    assert_commit_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !stk_empty);

    // The full flag is only observed, never reached with a push
    assert_full_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> !beats);
endmodule

// File: tb/tb_pvic_top.sv
module tb_pvic_top;
    localparam int CLK_P = 10;
    localparam int NS    = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src_i = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Bench model of the requirements
    logic [4:0]  m_cfg [NS];
    logic [31:0] m_vec [NS];
    logic [31:0] m_dflt;
    bit          m_src [NS];
    bit          m_ep  [NS];
    int          m_stk [8];
    int          m_sp;

    pvic_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (src_i),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_n     (irq_n)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic bit m_pend(int i);
        return m_cfg[i][3] ? m_ep[i] : m_src[i];
    endfunction

    function automatic int m_best();
        int b = -1;
        for (int i = 0; i < NS; i++) begin
            if (m_cfg[i][4] && m_pend(i)) begin
                if (b < 0 || m_cfg[i][2:0] > m_cfg[b][2:0]) b = i;
            end
        end
        return b;
    endfunction

    function automatic bit m_beats();
        int b = m_best();
        if (b < 0) return 1'b0;
        if (m_sp == 0) return 1'b1;
        return int'(m_cfg[b][2:0]) > m_stk[m_sp-1];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #(CLK_P / 4) d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic check_irq(string req);
        #(CLK_P / 4);
        check(req, {31'd0, irq_n}, {31'd0, ~m_beats()});
    endtask

    task automatic set_cfg(int i, bit en, bit edg, int pr, string req);
        logic [4:0] c = {en, edg, 3'(pr)};
        bus_write(5'(i), {27'h7FFFFFF, c});
        m_cfg[i] = c;
        if (!edg) m_ep[i] = 1'b0;
        check_irq(req);
    endtask

    task automatic set_src(int i, bit v, string req);
        @(negedge clk);
        src_i[i] = v;
        repeat (4) @(posedge clk);
        #1;
        if (m_cfg[i][3] && v && !m_src[i]) m_ep[i] = 1'b1;
        m_src[i] = v;
        check_irq(req);
    endtask

    task automatic vec_read(string req);
        logic [31:0] d;
        logic [31:0] e;
        int b = m_best();
        bit hit = m_beats();
        bus_read(5'd16, d);
        if (hit) begin
            e = m_vec[b];
            if (m_cfg[b][3]) m_ep[b] = 1'b0;
            m_stk[m_sp] = int'(m_cfg[b][2:0]);
            m_sp++;
        end else begin
            e = m_dflt;
        end
        check(req, d, e);
        check_irq(req);
    endtask

    task automatic eoi(string req);
        bus_write(5'd17, 32'd0);
        if (m_sp > 0) m_sp--;
        check_irq(req);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] d;
        for (int i = 0; i < NS; i++) begin
            m_cfg[i] = '0; m_vec[i] = '0; m_src[i] = 1'b0; m_ep[i] = 1'b0;
        end
        m_dflt = '0;
        m_sp   = 0;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_n", {31'd0, irq_n}, 32'd1);
        bus_read(5'd3, d);  check("R1 cfg3", d, 32'd0);
        bus_read(5'd13, d); check("R1 vec5", d, 32'd0);
        bus_read(5'd18, d); check("R1 dflt", d, 32'd0);
        vec_read("R7 read at reset");

        // R2: layout and readback
        bus_write(5'd18, 32'hDEAD_0000); m_dflt = 32'hDEAD_0000;
        for (int i = 0; i < NS; i++) begin
            bus_write(5'(8 + i), 32'h1000 + 32'(i * 16));
            m_vec[i] = 32'h1000 + 32'(i * 16);
        end
        bus_write(5'd0, 32'hFFFF_FFFD);
        bus_read(5'd0, d);  check("R2 cfg0 readback", d, 32'h1D);
        bus_write(5'd0, 32'd0);
        bus_read(5'd11, d); check("R2 vec3 readback", d, 32'h1030);
        bus_read(5'd18, d); check("R2 dflt readback", d, 32'hDEAD_0000);

        // R3: a disabled source never requests
        set_cfg(5, 1'b0, 1'b0, 7, "R3 cfg");
        set_src(5, 1'b1, "R3 disabled source");
        check("R3 disabled literal", {31'd0, irq_n}, 32'd1);
        set_src(5, 1'b0, "R3");

        // R4: tie at equal priority goes to the lower index
        set_cfg(2, 1'b1, 1'b0, 4, "R4 cfg");
        set_cfg(5, 1'b1, 1'b0, 4, "R4 cfg");
        set_src(5, 1'b1, "R3 one pending");
        set_src(2, 1'b1, "R3 two pending");
        vec_read("R4 tie read");
        check("R5 irq released", {31'd0, irq_n}, 32'd1);
        vec_read("R7 equal level read");
        eoi("R6 level stays pending");
        check("R6 level literal", {31'd0, irq_n}, 32'd0);
        vec_read("R6 level re-read");
        eoi("R8");
        set_src(2, 1'b0, "R6 level dropped");
        vec_read("R4 remaining source");
        eoi("R8");
        set_src(5, 1'b0, "R3 idle");

        // R6 / R10: edge source
        set_cfg(1, 1'b1, 1'b1, 3, "R10 cfg");
        set_src(1, 1'b1, "R10 rising edge");
        vec_read("R6 edge commit");
        eoi("R10 held input no re-pend");
        check("R10 literal", {31'd0, irq_n}, 32'd1);
        vec_read("R10 held input gives default");
        set_src(1, 1'b0, "R10 falling edge");
        set_src(1, 1'b1, "R10 second edge");
        vec_read("R10 second commit");
        eoi("R8");
        set_src(1, 1'b0, "R10");

        // R3 / R8: nesting
        set_cfg(6, 1'b1, 1'b0, 6, "R8 cfg");
        set_cfg(4, 1'b1, 1'b0, 2, "R8 cfg");
        set_cfg(7, 1'b1, 1'b0, 2, "R8 cfg");
        set_cfg(3, 1'b1, 1'b0, 1, "R8 cfg");
        set_src(4, 1'b1, "R3");
        vec_read("R4 level 2");
        set_src(7, 1'b1, "R3 equal priority no preempt");
        check("R3 equal literal", {31'd0, irq_n}, 32'd1);
        set_src(6, 1'b1, "R3 higher preempts");
        check("R3 higher literal", {31'd0, irq_n}, 32'd0);
        vec_read("R5 nested commit");
        set_src(6, 1'b0, "R8");
        eoi("R8 restored level 2");
        set_src(4, 1'b0, "R8");
        eoi("R8 empty after pop");
        check("R8 lower source literal", {31'd0, irq_n}, 32'd0);
        vec_read("R4");
        eoi("R8");
        set_src(7, 1'b0, "R8");
        set_src(6, 1'b1, "R8");
        vec_read("R8 high level");
        set_src(3, 1'b1, "R3 lower held off");
        set_src(6, 1'b0, "R8");
        eoi("R8 lower source after pop");
        vec_read("R8");
        eoi("R8");
        set_src(3, 1'b0, "R8");

        // R9: end-of-interrupt on empty stack
        eoi("R9 empty pop");
        eoi("R9 second empty pop");
        set_src(2, 1'b1, "R9");
        vec_read("R9 commit after empty pops");
        set_src(5, 1'b1, "R9 equal level held off");
        check("R9 literal", {31'd0, irq_n}, 32'd1);
        eoi("R9");
        eoi("R9");
        eoi("R9");
        set_src(2, 1'b0, "R9");
        set_src(5, 1'b0, "R9");

        // Random phase
        for (int k = 0; k < 800; k++) begin
            int op = int'($urandom_range(0, 9));
            int s  = int'($urandom_range(0, NS - 1));
            case (op)
                0, 1, 2: set_src(s, ~m_src[s], "R3 random toggle");
                3, 4:    vec_read("R4 random read");
                5, 6:    eoi("R8 random eoi");
                7:       set_cfg(s, ($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
                                 int'($urandom_range(0, 7)), "R2 random cfg");
                8: begin
                    logic [31:0] v = $urandom;
                    bus_write(5'(8 + s), v);
                    m_vec[s] = v;
                    bus_read(5'(8 + s), d);
                    check("R2 random vec", d, v);
                end
                default: begin
                    bus_read(5'(s), d);
                    check("R2 random cfg read", d, {27'd0, m_cfg[s]});
                end
            endcase
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule